// File: doc/BRIEF.md
# Low Pin Count I/O Target Controller

This block is the target side of a Low Pin Count host bus, limited to I/O read and I/O write cycles. It watches the frame strobe (active low) and the 4-bit multiplexed address/data lane. It recognises a start clock and decodes the cycle-type nibble that follows. It then shifts in a 16-bit address, one nibble per clock, most significant nibble first. On a write it collects the data byte, least significant nibble first.

After the host-to-target turnaround, the block checks the address against a base/mask window. On a miss it lets the cycle go without touching the bus. On a hit it drives sync nibbles and presents the access on a simple register port, with an address, write data, a write request, a read request, read data and a ready input. While the register port holds ready low, the block inserts long-wait syncs. It gives up with an error sync after a parameterised number of them. A read returns its byte over two clocks. Every cycle ends with a target-to-host turnaround, unless the host starts a new frame straight after the read data.

The state machine uses one state per bus clock. Asserting the frame strobe in any state restarts decoding. If the lane reads 0000 at that point, the block takes it as a new start. If it reads any other value, the block drops back to idle.

Top module: `lpc_io_target`

## Requirements
- R1: After reset, and while idle with the frame strobe high, the block keeps `lad_oe`, `reg_wr` and `reg_rd` low. A start is the frame strobe low together with lane value 0000. Several start clocks in a row are accepted, and the cycle type is taken from the first clock in which the frame strobe is high again.
- R2: The cycle-type nibble is decoded with bits [3:2]=00 meaning I/O and bit 1 giving the direction, 1 for write and 0 for read. Any other type (bits [3:2] not 00) returns the block to idle, and the rest of that cycle is ignored: no bus drive and no request.
- R3: The next four clocks carry the address, bits [15:12] first and bits [3:0] last. The address is shown on `reg_addr` and held steady throughout sync.
- R4: On a write, the two clocks after the address carry the data, bits [3:0] first and then bits [7:4]. The byte is shown on `reg_wdata`.
- R5: While the host owns the lane (idle, start, address, write data and both host-to-target turnaround clocks), `lad_oe` is low.
- R6: An address hits when `(addr & ADDR_MASK) == (ADDR_BASE & ADDR_MASK)`. On a miss, the block returns to idle after the second turnaround clock without driving the lane and without a request.
- R7: On a hit, the block enters sync with `lad_oe` high and raises `reg_wr` (write) or `reg_rd` (read). It drives 0110 while `reg_ready` is low and 0000 in the clock `reg_ready` is high, and that clock completes the access.
- R8: After MAX_WAIT clocks of 0110, the block drives 1010 for one clock with no request, skips any read data, and moves to the final turnaround. The timeout takes precedence over `reg_ready` in that clock.
- R9: On a read, the byte present on `reg_rdata` in the completing sync clock is driven over the next two clocks, bits [3:0] first.
- R10: The final turnaround drives 1111 with `lad_oe` high for one clock, releases the lane for one clock, and then returns to idle.
- R11: The frame strobe low in any state abandons the cycle in progress. With lane 0000 the block goes to start, and with any other value it goes to idle. An abandoned write is never committed.
- R12: A start given during the second read-data clock takes the block straight to start, skipping the final turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Lane value sampled from the bus |
| lad_out | output | 4 | Lane value driven by the target |
| lad_oe | output | 1 | Lane output enable |
| reg_addr | output | 16 | Decoded I/O address |
| reg_wdata | output | 8 | Write data byte |
| reg_wr | output | 1 | Write request, held during sync |
| reg_rd | output | 1 | Read request, held during sync |
| reg_rdata | input | 8 | Read data, sampled in the completing sync clock |
| reg_ready | input | 1 | Register port completes the access |

## Verification
The assertions assume that the host behaves like a real bus master. The frame strobe rises once a start is done. The lane value seen while the target drives comes only from the target. `reg_ready` is meaningful only while a request is up. The stimulus follows this rule: the bench raises `reg_ready` only inside sync, and it asserts the frame strobe mid-cycle only where an abort or a back-to-back start is the point of the test. It keeps the lane at 1111 through the turnarounds. The sweeps cover a 32-address range that straddles the decode window, with every wait count from zero up to one past the timeout.

// File: rtl/lpc_io_target.sv
module lpc_io_target #(
  parameter logic [15:0] ADDR_BASE = 16'h0060,
  parameter logic [15:0] ADDR_MASK = 16'hFFF0,
  parameter int          MAX_WAIT  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [3:0]  lad_in,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic [15:0] reg_addr,
  output logic [7:0]  reg_wdata,
  output logic        reg_wr,
  output logic        reg_rd,
  input  logic [7:0]  reg_rdata,
  input  logic        reg_ready
);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(MAX_WAIT);
  localparam logic [3:0] SYNC_OK  = 4'b0000;
  localparam logic [3:0] SYNC_LNG = 4'b0110;
  localparam logic [3:0] SYNC_ERR = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADR1, S_ADR2, S_ADR3, S_ADR4, S_WD1, S_WD2,
    S_TAR1, S_TAR2, S_SYNC, S_RD1, S_RD2, S_FT1, S_FT2
  } st_t;

  st_t st, nx;
  logic              is_wr;
  logic [15:0]       addr;
  logic [7:0]        wdata, rdata;
  logic [WAIT_W-1:0] wcnt;

  wire hit     = ((addr ^ ADDR_BASE) & ADDR_MASK) == 16'h0000;
  wire in_sync = st == S_SYNC;
  wire tmo     = in_sync && wcnt == WAIT_LIM;
  wire done    = in_sync && !tmo && reg_ready;

  assign reg_addr  = addr;
  assign reg_wdata = wdata;
  assign reg_wr    = in_sync && is_wr && !tmo;
  assign reg_rd    = in_sync && !is_wr && !tmo;

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:  nx = S_IDLE;
      S_START: if (frame_n) nx = (lad_in[3:2] == 2'b00) ? S_ADR1 : S_IDLE;
      S_ADR1:  nx = S_ADR2;
      S_ADR2:  nx = S_ADR3;
      S_ADR3:  nx = S_ADR4;
      S_ADR4:  nx = is_wr ? S_WD1 : S_TAR1;
      S_WD1:   nx = S_WD2;
      S_WD2:   nx = S_TAR1;
      S_TAR1:  nx = S_TAR2;
      S_TAR2:  nx = hit ? S_SYNC : S_IDLE;
      S_SYNC: begin
        if (tmo)            nx = S_FT1;
        else if (reg_ready) nx = is_wr ? S_FT1 : S_RD1;
      end
      S_RD1:   nx = S_RD2;
      S_RD2:   nx = S_FT1;
      S_FT1:   nx = S_FT2;
      S_FT2:   nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
    if (!frame_n) nx = (lad_in == 4'h0) ? S_START : S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      is_wr <= 1'b0;
      addr  <= '0;
      wdata <= '0;
      rdata <= '0;
      wcnt  <= '0;
    end else begin
      st   <= nx;
      wcnt <= (in_sync && nx == S_SYNC) ? wcnt + 1'b1 : '0;
      case (st)
        S_START: if (frame_n) is_wr <= lad_in[1];
        S_ADR1, S_ADR2, S_ADR3, S_ADR4: addr <= {addr[11:0], lad_in};
        S_WD1:   wdata[3:0] <= lad_in;
        S_WD2:   wdata[7:4] <= lad_in;
        S_SYNC:  if (done && !is_wr) rdata <= reg_rdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    lad_oe  = 1'b0;
    lad_out = 4'hF;
    case (st)
      S_SYNC: begin
        lad_oe  = 1'b1;
        lad_out = tmo ? SYNC_ERR : (reg_ready ? SYNC_OK : SYNC_LNG);
      end
      S_RD1: begin lad_oe = 1'b1; lad_out = rdata[3:0]; end
      S_RD2: begin lad_oe = 1'b1; lad_out = rdata[7:4]; end
      S_FT1: lad_oe = 1'b1;
      default: ;
    endcase
  end

  // R2
  bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && frame_n && lad_in[3:2] != 2'b00) |=> st == S_IDLE);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |=> $stable(reg_addr));
  // R6
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAR2 && frame_n && !hit) |=> !lad_oe);
  // R7
  req_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (lad_oe && lad_out != SYNC_ERR));
  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WAIT_LIM);
  // R10
  ftar_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FT1 && frame_n) |=> (st == S_FT2 && !lad_oe));
  // R11
  abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && lad_in == 4'h0) |=> st == S_START);
endmodule

// File: tb/test_lpc_io_target.sv
module test_lpc_io_target;
  localparam int MW = 3;
  localparam logic [15:0] BASE = 16'h0060;
  localparam logic [15:0] MASK = 16'hFFF0;

  logic clk = 1'b0, rst_n = 1'b0, frame_n = 1'b1, reg_ready = 1'b0;
  logic [3:0] lad_in = 4'hF;
  logic [7:0] reg_rdata = 8'h00;
  logic [3:0] lad_out;
  logic lad_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;
  logic [7:0] reg_wdata;

  int total = 0, bad = 0, commits = 0;
  logic [7:0] last_d = 8'h00;

  always #10 clk = ~clk;

  lpc_io_target #(.ADDR_BASE(BASE), .ADDR_MASK(MASK), .MAX_WAIT(MW)) i_lpc_io_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_ready(reg_ready));

  always @(posedge clk)
    if (reg_wr && reg_ready) begin
      commits <= commits + 1;
      last_d  <= reg_wdata;
    end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drv(logic f, logic [3:0] d);
    @(negedge clk);
    frame_n = f;
    lad_in  = d;
  endtask

  task automatic hdr(bit lead, bit wr, logic [15:0] a);
    if (lead) drv(1'b0, 4'h0);
    drv(1'b1, wr ? 4'b0010 : 4'b0000);
    for (int i = 3; i >= 0; i--) drv(1'b1, a[i*4 +: 4]);
  endtask

  task automatic ftail();
    @(negedge clk); reg_ready = 1'b0; frame_n = 1'b1; lad_in = 4'hF; #1;
    chk("R10 ft1 oe", lad_oe, 1); chk("R10 ft1 lad", lad_out, 4'hF);
    @(negedge clk); chk("R10 ft2 oe", lad_oe, 0);
    @(negedge clk); chk("R1 idle oe", lad_oe, 0);
  endtask

  // leaves the bench at the negedge of the last sync clock; returns 1 when completed
  task automatic sync_loop(bit wr, logic [15:0] a, logic [7:0] d, int waits, output bit ok);
    ok = 1'b0;
    for (int w = 0; ; w++) begin
      reg_ready = (w == waits);
      #1;
      if (w == MW) begin
        chk("R8 err sync", lad_out, 4'b1010); chk("R8 oe", lad_oe, 1);
        chk("R8 no req", {reg_wr, reg_rd}, 0);
        break;
      end
      chk("R7 oe", lad_oe, 1);
      chk("R7 sync", lad_out, (w == waits) ? 4'b0000 : 4'b0110);
      chk("R7 req", {reg_wr, reg_rd}, wr ? 2'b10 : 2'b01);
      chk("R3 addr", reg_addr, a);
      if (wr) chk("R4 wdata", reg_wdata, d);
      if (w == waits) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d, int waits, bit lead);
    bit hit = ((a ^ BASE) & MASK) == 16'h0;
    bit ok;
    int c0;
    hdr(lead, 1'b1, a);
    drv(1'b1, d[3:0]); drv(1'b1, d[7:4]);
    drv(1'b1, 4'hF); chk("R5 tar1 oe", lad_oe, 0);
    drv(1'b1, 4'hF); chk("R5 tar2 oe", lad_oe, 0);
    c0 = commits;
    @(negedge clk);
    if (!hit) begin
      chk("R6 miss oe", lad_oe, 0); chk("R6 miss req", {reg_wr, reg_rd}, 0);
      @(negedge clk); chk("R6 miss oe2", lad_oe, 0);
      chk("R6 no commit", commits, c0);
      return;
    end
    sync_loop(1'b1, a, d, waits, ok);
    ftail();
    chk("R7 commit count", commits, c0 + (ok ? 1 : 0));
    if (ok) chk("R4 committed data", last_d, d);
  endtask

  task automatic io_rd(logic [15:0] a, logic [7:0] d, int waits, bit lead, bit b2b);
    bit hit = ((a ^ BASE) & MASK) == 16'h0;
    bit ok;
    hdr(lead, 1'b0, a);
    drv(1'b1, 4'hF); chk("R5 rtar1 oe", lad_oe, 0);
    drv(1'b1, 4'hF); chk("R5 rtar2 oe", lad_oe, 0);
    @(negedge clk);
    if (!hit) begin
      chk("R6 rmiss oe", lad_oe, 0); chk("R6 rmiss req", {reg_wr, reg_rd}, 0);
      @(negedge clk); chk("R6 rmiss oe2", lad_oe, 0);
      return;
    end
    reg_rdata = d;
    sync_loop(1'b0, a, d, waits, ok);
    if (ok) begin
      @(negedge clk); reg_ready = 1'b0; reg_rdata = ~d; #1;
      chk("R9 oe", lad_oe, 1); chk("R9 low nibble", lad_out, d[3:0]);
      @(negedge clk); #1;
      chk("R9 high nibble", lad_out, d[7:4]);
      if (b2b) begin
        frame_n = 1'b0; lad_in = 4'h0;
        @(negedge clk); chk("R12 skip final tar", lad_oe, 0);
        return;
      end
    end
    ftail();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", lad_oe, 0);
    chk("R1 reset req", {reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    // idle with frame high and assorted lane values
    for (int v = 0; v < 16; v++) begin
      drv(1'b1, v[3:0]);
      chk("R1 idle quiet", {lad_oe, reg_wr, reg_rd}, 0);
    end
    // several start clocks in a row
    drv(1'b0, 4'h0); drv(1'b0, 4'h0);
    io_wr(16'h0063, 8'hA5, 0, 1'b1);
    // non-I/O cycle type is ignored
    c0 = commits;
    drv(1'b0, 4'h0); drv(1'b1, 4'b0110);
    for (int i = 0; i < 12; i++) begin
      drv(1'b1, (i % 3 == 0) ? 4'h6 : 4'hF);
      chk("R2 ignored type", {lad_oe, reg_wr, reg_rd}, 0);
    end
    chk("R2 no commit", commits, c0);
    // abort during write data with a new start
    c0 = commits;
    hdr(1'b1, 1'b1, 16'h0061); drv(1'b1, 4'h5);
    drv(1'b0, 4'h0);
    io_wr(16'h0064, 8'h3C, 1, 1'b0);
    chk("R11 one commit", commits, c0 + 1);
    chk("R11 new data", last_d, 8'h3C);
    // abort to idle with non-zero lane
    c0 = commits;
    hdr(1'b1, 1'b1, 16'h0062); drv(1'b0, 4'h5);
    for (int i = 0; i < 4; i++) begin
      drv(1'b1, 4'hF);
      chk("R11 idle after abort", {lad_oe, reg_wr}, 0);
    end
    chk("R11 no commit", commits, c0);
    // abort during sync
    hdr(1'b1, 1'b1, 16'h0065); drv(1'b1, 4'h1); drv(1'b1, 4'h2);
    drv(1'b1, 4'hF); drv(1'b1, 4'hF);
    @(negedge clk); #1;
    chk("R7 sync before abort", lad_out, 4'b0110);
    frame_n = 1'b0; lad_in = 4'hF;
    @(negedge clk); frame_n = 1'b1;
    chk("R11 sync abort released", lad_oe, 0);
    chk("R11 sync abort no commit", commits, c0);
    // back-to-back after read data
    io_rd(16'h006A, 8'h96, 0, 1'b1, 1'b1);
    io_wr(16'h006B, 8'h5A, 0, 1'b0);
    // sweep across the window edge and all wait counts
    for (int i = 0; i < 32; i++) begin
      io_wr(16'h0050 + 16'(i), 8'(i * 37 + 5), i % (MW + 2), 1'b1);
      io_rd(16'h0050 + 16'(i), 8'(~(i * 11)), (i + 2) % (MW + 2), 1'b1, 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule